// File: doc/BRIEF.md
# Multi-Image Boot Header Parser

This block sits behind a serial flash reader. It takes the bytes read from flash address 0 onward and parses the boot header that describes where up to four configuration images live. The header is a run of five fixed 32-byte records. The first record carries the boot-mode control byte, which enables cold boot, warm boot or both. Each of the next four records carries one image vector: a flash read command byte followed by a 24-bit start address, most significant byte first. Every record opens with the four-byte sync word 7E AA 99 7E. Bytes that are neither sync, control nor vector fields are not checked.

Once the header has been parsed, a boot sequencer asks for an image by boot type (cold or warm) and image index. One clock later the block answers with either the image's start address and read command, or a no-image flag. The answer is no-image when:
- the parse is incomplete;
- a record lost its sync word;
- the control byte holds an unsupported mode;
- the requested boot type is disabled.

Bytes arrive on a valid/ready stream. A byte is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` stays high through all 160 header bytes, so the block never stalls a header in progress. After the last byte, `in_ready` drops and stays low until reset, which holds off the source. The source may insert idle cycles at any point. A synchronous reset clears every parsed field and restarts the parse at flash byte 0.

Top module: `boot_hdr_parser`

## Requirements
- R1: While reset is held and in the cycle after it is released, in_ready is 1 and hdr_done, hdr_err, mode_err, cold_en, warm_en, addr_valid and no_image are all 0.
- R2: A byte is consumed only on a clock edge where in_valid and in_ready are both 1. Idle cycles with in_valid low, whatever in_data holds, do not change the parse.
- R3: After exactly 160 consumed bytes (five 32-byte records), hdr_done goes to 1 and in_ready goes to 0. Both hold until reset, and later bytes offered with in_valid high change nothing.
- R4: The control byte is byte offset 6 of record 0. The value 0x30 sets cold_en and warm_en, 0x20 sets only cold_en, and 0x10 sets only warm_en.
- R5: Any other control value sets mode_err and leaves cold_en and warm_en at 0, so every lookup answers no_image.
- R6: In record k+1 (k = 0..3), offset 8 is image k's read command and offsets 9, 10 and 11 are its address bits 23:16, 15:8 and 7:0. A successful lookup returns exactly these values on img_cmd and img_addr.
- R7: If any record's first four bytes differ from 7E AA 99 7E, hdr_err goes to 1 and stays at 1 until reset, and every lookup answers no_image.
- R8: Two or more images may hold the same address. This is not an error, and each of them is returned normally.
- R9: In the cycle after lk_req is high, exactly one of addr_valid and no_image is 1. addr_valid is chosen when the parse is done, hdr_err is 0, the image's record was parsed, and the boot type is enabled (lk_warm = 0 selects cold and needs cold_en; lk_warm = 1 selects warm and needs warm_en). Without a request, both are 0.
- R10: A lookup issued before hdr_done is 1 answers no_image.
- R11: Asserting rst in the middle of a parse discards the partial header, and the next consumed byte is treated as flash byte 0.
- R12: Padding bytes and the fixed bytes at offsets 4, 5 and 7 are not checked, so nonzero padding does not prevent a valid parse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Parser accepts a byte |
| in_data | input | 8 | Stream byte, in flash address order |
| lk_req | input | 1 | Lookup request, one cycle per request |
| lk_warm | input | 1 | Boot type of the lookup: 0 cold, 1 warm |
| lk_idx | input | 2 | Image index of the lookup |
| addr_valid | output | 1 | Lookup hit; address and command are valid |
| no_image | output | 1 | Lookup miss |
| img_addr | output | 24 | Start byte address of the selected image |
| img_cmd | output | 8 | Flash read command of the selected image |
| hdr_done | output | 1 | All five records consumed |
| hdr_err | output | 1 | A record start lacked the sync word |
| mode_err | output | 1 | Control byte held an unsupported mode |
| cold_en | output | 1 | Cold boot enabled by the header |
| warm_en | output | 1 | Warm boot enabled by the header |

## Verification
The assertions take for granted that reset is applied before the first byte, and that lk_req is only sampled as a single-cycle strobe whose index stays within the four images. The exclusivity and after-request properties rely on that. The stimulus drives every input on the falling edge, raises lk_req for exactly one cycle per lookup, and keeps lk_idx in range. It offers extra bytes after the header is complete only to probe back-pressure, never to feed a second header without a reset.

// File: rtl/boot_hdr_pkg.sv
package boot_hdr_pkg;
  localparam int REC_BYTES   = 32;
  localparam int NUM_IMG     = 4;
  localparam int SYNC_LEN    = 4;
  localparam int VEC_ADDR_W  = 24;
  localparam int CTRL_OFF    = 6;
  localparam int CMD_OFF     = 8;
  localparam int ADDR_OFF    = 9;

  localparam logic [7:0] MODE_BOTH = 8'h30;
  localparam logic [7:0] MODE_COLD = 8'h20;
  localparam logic [7:0] MODE_WARM = 8'h10;

  typedef struct packed {
    logic [7:0]            cmd;
    logic [VEC_ADDR_W-1:0] addr;
  } vec_t;

  function automatic logic [7:0] sync_byte(input logic [1:0] pos);
    case (pos)
      2'd0:    sync_byte = 8'h7E;
      2'd1:    sync_byte = 8'hAA;
      2'd2:    sync_byte = 8'h99;
      default: sync_byte = 8'h7E;
    endcase
  endfunction
endpackage

// File: rtl/bhp_stream_counter.sv
module bhp_stream_counter #(
  parameter int NUM_REC   = 5,
  parameter int REC_BYTES = 32,
  localparam int OFF_W    = $clog2(REC_BYTES),
  localparam int REC_W    = $clog2(NUM_REC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             beat,
  output logic [REC_W-1:0] rec,
  output logic [OFF_W-1:0] off,
  output logic             done
);
  assign in_ready = !done;
  assign beat     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      rec  <= '0;
      off  <= '0;
      done <= 1'b0;
    end else if (beat) begin
      if (off == OFF_W'(REC_BYTES - 1)) begin
        off <= '0;
        if (rec == REC_W'(NUM_REC - 1)) done <= 1'b1;
        else rec <= rec + 1'b1;
      end else begin
        off <= off + 1'b1;
      end
    end
  end

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    done |=> done && !in_ready); // R3
  AST_REC_RANGE: assert property (@(posedge clk) disable iff (rst)
    rec <= REC_W'(NUM_REC - 1)); // R3
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(off) && $stable(rec)); // R2
endmodule

// File: rtl/bhp_sync_check.sv
module bhp_sync_check
  import boot_hdr_pkg::*;
#(
  parameter int OFF_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             beat,
  input  logic [OFF_W-1:0] off,
  input  logic [7:0]       data,
  output logic             sync_fail
);
  logic run_q;
  logic byte_hit;

  assign byte_hit = (data == sync_byte(off[1:0]));

  always_ff @(posedge clk) begin
    if (rst) run_q <= 1'b0;
    else if (beat && off < OFF_W'(SYNC_LEN))
      run_q <= ((off == '0) ? 1'b1 : run_q) && byte_hit;
  end

  assign sync_fail = beat && (off == OFF_W'(SYNC_LEN - 1)) && !(run_q && byte_hit);
endmodule

// File: rtl/bhp_field_capture.sv
module bhp_field_capture
  import boot_hdr_pkg::*;
#(
  parameter int N_IMG = 4,
  parameter int REC_W = 3,
  parameter int OFF_W = 5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   beat,
  input  logic [REC_W-1:0]       rec,
  input  logic [OFF_W-1:0]       off,
  input  logic [7:0]             data,
  input  logic                   sync_fail,
  output logic                   cold_en,
  output logic                   warm_en,
  output logic                   mode_err,
  output logic                   hdr_err,
  output logic [N_IMG-1:0]       vec_ok,
  output vec_t [N_IMG-1:0]       vecs
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cold_en  <= 1'b0;
      warm_en  <= 1'b0;
      mode_err <= 1'b0;
      hdr_err  <= 1'b0;
    end else begin
      if (sync_fail) hdr_err <= 1'b1;
      if (beat && rec == '0 && off == OFF_W'(CTRL_OFF)) begin
        cold_en  <= (data == MODE_BOTH) || (data == MODE_COLD);
        warm_en  <= (data == MODE_BOTH) || (data == MODE_WARM);
        mode_err <= !((data == MODE_BOTH) || (data == MODE_COLD) || (data == MODE_WARM));
      end
    end
  end

  for (genvar g = 0; g < N_IMG; g++) begin : g_img
    logic rec_hit;
    assign rec_hit = beat && (rec == REC_W'(g + 1));
    always_ff @(posedge clk) begin
      if (rst) begin
        vecs[g]   <= '0;
        vec_ok[g] <= 1'b0;
      end else if (sync_fail || hdr_err) begin
        vec_ok[g] <= 1'b0;
      end else if (rec_hit) begin
        case (off)
          OFF_W'(CMD_OFF):      vecs[g].cmd          <= data;
          OFF_W'(ADDR_OFF):     vecs[g].addr[23:16]  <= data;
          OFF_W'(ADDR_OFF + 1): vecs[g].addr[15:8]   <= data;
          OFF_W'(ADDR_OFF + 2): begin
            vecs[g].addr[7:0] <= data;
            vec_ok[g]         <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  AST_MODE_ERR_NO_EN: assert property (@(posedge clk) disable iff (rst)
    mode_err |-> !cold_en && !warm_en); // R5
  AST_HDR_ERR_NO_VEC: assert property (@(posedge clk) disable iff (rst)
    hdr_err |-> (vec_ok == '0)); // R7
  AST_HDR_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    hdr_err |=> hdr_err); // R7
endmodule

// File: rtl/bhp_lookup.sv
module bhp_lookup
  import boot_hdr_pkg::*;
#(
  parameter int N_IMG = 4,
  localparam int IDX_W = (N_IMG > 1) ? $clog2(N_IMG) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  lk_req,
  input  logic                  lk_warm,
  input  logic [IDX_W-1:0]      lk_idx,
  input  logic                  done,
  input  logic                  hdr_err,
  input  logic                  cold_en,
  input  logic                  warm_en,
  input  logic [N_IMG-1:0]      vec_ok,
  input  vec_t [N_IMG-1:0]      vecs,
  output logic                  addr_valid,
  output logic                  no_image,
  output logic [VEC_ADDR_W-1:0] img_addr,
  output logic [7:0]            img_cmd
);
  logic hit;
  assign hit = done && !hdr_err && vec_ok[lk_idx] && (lk_warm ? warm_en : cold_en);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_valid <= 1'b0;
      no_image   <= 1'b0;
      img_addr   <= '0;
      img_cmd    <= '0;
    end else begin
      addr_valid <= lk_req && hit;
      no_image   <= lk_req && !hit;
      if (lk_req && hit) begin
        img_addr <= vecs[lk_idx].addr;
        img_cmd  <= vecs[lk_idx].cmd;
      end
    end
  end

  AST_RESP_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(addr_valid && no_image)); // R9
  AST_RESP_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    lk_req |=> (addr_valid || no_image)); // R9
  AST_NO_EARLY_HIT: assert property (@(posedge clk) disable iff (rst)
    (lk_req && !done) |=> no_image); // R10
endmodule

// File: rtl/boot_hdr_parser.sv
module boot_hdr_parser
  import boot_hdr_pkg::*;
#(
  parameter int N_IMG  = NUM_IMG,
  parameter int RBYTES = REC_BYTES,
  localparam int N_REC = N_IMG + 1,
  localparam int OFF_W = $clog2(RBYTES),
  localparam int REC_W = $clog2(N_REC),
  localparam int IDX_W = (N_IMG > 1) ? $clog2(N_IMG) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [7:0]            in_data,
  input  logic                  lk_req,
  input  logic                  lk_warm,
  input  logic [IDX_W-1:0]      lk_idx,
  output logic                  addr_valid,
  output logic                  no_image,
  output logic [VEC_ADDR_W-1:0] img_addr,
  output logic [7:0]            img_cmd,
  output logic                  hdr_done,
  output logic                  hdr_err,
  output logic                  mode_err,
  output logic                  cold_en,
  output logic                  warm_en
);
  logic             beat;
  logic [REC_W-1:0] rec;
  logic [OFF_W-1:0] off;
  logic             sync_fail;
  logic [N_IMG-1:0] vec_ok;
  vec_t [N_IMG-1:0] vecs;

  bhp_stream_counter #(.NUM_REC(N_REC), .REC_BYTES(RBYTES)) u_cnt (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .beat(beat), .rec(rec), .off(off), .done(hdr_done));

  bhp_sync_check #(.OFF_W(OFF_W)) u_sync (
    .clk(clk), .rst(rst), .beat(beat), .off(off), .data(in_data),
    .sync_fail(sync_fail));

  bhp_field_capture #(.N_IMG(N_IMG), .REC_W(REC_W), .OFF_W(OFF_W)) u_cap (
    .clk(clk), .rst(rst), .beat(beat), .rec(rec), .off(off), .data(in_data),
    .sync_fail(sync_fail), .cold_en(cold_en), .warm_en(warm_en),
    .mode_err(mode_err), .hdr_err(hdr_err), .vec_ok(vec_ok), .vecs(vecs));

  bhp_lookup #(.N_IMG(N_IMG)) u_lk (
    .clk(clk), .rst(rst), .lk_req(lk_req), .lk_warm(lk_warm), .lk_idx(lk_idx),
    .done(hdr_done), .hdr_err(hdr_err), .cold_en(cold_en), .warm_en(warm_en),
    .vec_ok(vec_ok), .vecs(vecs), .addr_valid(addr_valid), .no_image(no_image),
    .img_addr(img_addr), .img_cmd(img_cmd));

  AST_HIT_NEEDS_CLEAN: assert property (@(posedge clk) disable iff (rst)
    addr_valid |-> hdr_done && !hdr_err && !mode_err); // R9
endmodule

// File: tb/tb_boot_hdr_parser.sv
module tb_boot_hdr_parser;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = 8'h00;
  logic        lk_req = 1'b0;
  logic        lk_warm = 1'b0;
  logic [1:0]  lk_idx = 2'd0;
  logic        addr_valid, no_image;
  logic [23:0] img_addr;
  logic [7:0]  img_cmd;
  logic        hdr_done, hdr_err, mode_err, cold_en, warm_en;

  int checks = 0;
  int errors = 0;
  logic [7:0]  hdr [160];
  logic [23:0] v_addr [4];
  logic [7:0]  v_cmd [4];

  always #2 clk = ~clk;

  boot_hdr_parser dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .lk_req(lk_req), .lk_warm(lk_warm), .lk_idx(lk_idx), .addr_valid(addr_valid),
    .no_image(no_image), .img_addr(img_addr), .img_cmd(img_cmd), .hdr_done(hdr_done),
    .hdr_err(hdr_err), .mode_err(mode_err), .cold_en(cold_en), .warm_en(warm_en));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; lk_req = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic build(input logic [7:0] ctrl, input int bad_rec, input logic [7:0] pad);
    for (int r = 0; r < 5; r++) begin
      for (int o = 0; o < 32; o++) begin
        logic [7:0] b;
        b = pad;
        case (o)
          0: b = 8'h7E;
          1: b = (r == bad_rec) ? 8'h55 : 8'hAA;
          2: b = 8'h99;
          3: b = 8'h7E;
          4: b = 8'h92;
          5: b = 8'h00;
          default: ;
        endcase
        if (r == 0 && o == 6) b = ctrl;
        if (r > 0) begin
          if (o == 6) b = 8'h00;
          if (o == 7) b = 8'h44;
          if (o == 8) b = v_cmd[r-1];
          if (o == 9) b = v_addr[r-1][23:16];
          if (o == 10) b = v_addr[r-1][15:8];
          if (o == 11) b = v_addr[r-1][7:0];
        end
        hdr[r*32+o] = b;
      end
    end
  endtask

  task automatic stream(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      if (gap != 0 && (i % gap) == 0) begin
        @(negedge clk);
        in_valid = 1'b0; in_data = 8'hC3;
      end
      @(negedge clk);
      in_valid = 1'b1; in_data = hdr[i];
    end
    @(negedge clk);
    in_valid = 1'b0; in_data = 8'h00;
  endtask

  task automatic lookup(input string tag, input logic warm, input logic [1:0] idx,
                        input logic exp_hit);
    @(negedge clk);
    lk_req = 1'b1; lk_warm = warm; lk_idx = idx;
    @(negedge clk);
    lk_req = 1'b0;
    chk({tag, " addr_valid"}, 32'(addr_valid), 32'(exp_hit));
    chk({tag, " no_image"}, 32'(no_image), 32'(!exp_hit));
    if (exp_hit) begin
      chk({tag, " addr"}, 32'(img_addr), 32'(v_addr[idx]));
      chk({tag, " cmd"}, 32'(img_cmd), 32'(v_cmd[idx]));
    end
    @(negedge clk);
    chk({tag, " idle"}, 32'({addr_valid, no_image}), 32'd0);
  endtask

  task automatic set_vecs(input logic [23:0] a0, input logic [23:0] a1,
                          input logic [23:0] a2, input logic [23:0] a3);
    v_addr[0] = a0; v_addr[1] = a1; v_addr[2] = a2; v_addr[3] = a3;
    v_cmd[0] = 8'h0B; v_cmd[1] = 8'h03; v_cmd[2] = 8'h0B; v_cmd[3] = 8'h3B;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 in_ready", 32'(in_ready), 32'd1);
    chk("R1 status", 32'({hdr_done, hdr_err, mode_err, cold_en, warm_en}), 32'd0);
    chk("R1 lookup outs", 32'({addr_valid, no_image}), 32'd0);
  endtask

  task automatic t_both_dup();
    do_reset();
    set_vecs(24'h100000, 24'h200000, 24'h300000, 24'h300000);
    build(8'h30, -1, 8'h00);
    stream(160, 7);   // R2: idle cycles carry junk data
    chk("R3 done", 32'(hdr_done), 32'd1);
    chk("R3 ready low", 32'(in_ready), 32'd0);
    chk("R4 both enables", 32'({cold_en, warm_en, mode_err, hdr_err}), 32'b1100);
    for (int i = 0; i < 4; i++) begin
      lookup("R6 cold", 1'b0, 2'(i), 1'b1);
      lookup("R9 warm", 1'b1, 2'(i), 1'b1);
    end
    lookup("R8 duplicate idx3", 1'b0, 2'd3, 1'b1);
    // R3: bytes offered after completion are not consumed
    @(negedge clk);
    in_valid = 1'b1; in_data = 8'h00;
    repeat (5) @(negedge clk);
    chk("R3 ready held low", 32'(in_ready), 32'd0);
    in_valid = 1'b0;
    chk("R3 no effect", 32'({hdr_done, hdr_err, cold_en, warm_en}), 32'b1011);
    lookup("R3 vector intact", 1'b0, 2'd1, 1'b1);
  endtask

  task automatic t_cold_only();
    do_reset();
    set_vecs(24'h012345, 24'h6789AB, 24'hCDEF01, 24'hFFFFFF);
    build(8'h20, -1, 8'hA5);   // R12: nonzero padding
    stream(160, 0);
    chk("R4 cold only", 32'({cold_en, warm_en, mode_err}), 32'b100);
    chk("R12 no hdr_err", 32'(hdr_err), 32'd0);
    lookup("R12 padded cold", 1'b0, 2'd2, 1'b1);
    lookup("R9 warm disabled", 1'b1, 2'd2, 1'b0);
  endtask

  task automatic t_warm_only();
    do_reset();
    set_vecs(24'h040000, 24'h080000, 24'h0C0000, 24'h100000);
    build(8'h10, -1, 8'h00);
    stream(160, 3);
    chk("R4 warm only", 32'({cold_en, warm_en, mode_err}), 32'b010);
    lookup("R4 warm hit", 1'b1, 2'd0, 1'b1);
    lookup("R9 cold disabled", 1'b0, 2'd0, 1'b0);
  endtask

  task automatic t_bad_mode();
    do_reset();
    set_vecs(24'h100000, 24'h200000, 24'h300000, 24'h400000);
    build(8'h44, -1, 8'h00);
    stream(160, 0);
    chk("R5 mode_err", 32'({mode_err, cold_en, warm_en}), 32'b100);
    lookup("R5 cold miss", 1'b0, 2'd1, 1'b0);
    lookup("R5 warm miss", 1'b1, 2'd1, 1'b0);
  endtask

  task automatic t_bad_sync();
    do_reset();
    set_vecs(24'h100000, 24'h200000, 24'h300000, 24'h400000);
    build(8'h30, 3, 8'h00);
    stream(160, 0);
    chk("R7 hdr_err", 32'(hdr_err), 32'd1);
    chk("R7 done still", 32'(hdr_done), 32'd1);
    lookup("R7 good record dropped", 1'b0, 2'd0, 1'b0);
    lookup("R7 bad record", 1'b1, 2'd2, 1'b0);
    do_reset();
    build(8'h30, 0, 8'h00);
    stream(160, 0);
    chk("R7 hdr_err rec0", 32'(hdr_err), 32'd1);
    lookup("R7 rec0 miss", 1'b0, 2'd3, 1'b0);
  endtask

  task automatic t_early_and_restart();
    do_reset();
    set_vecs(24'hAAAAAA, 24'hBBBBBB, 24'hCCCCCC, 24'hDDDDDD);
    build(8'h30, -1, 8'h00);
    stream(50, 0);
    chk("R10 not done", 32'(hdr_done), 32'd0);
    lookup("R10 early", 1'b0, 2'd0, 1'b0);
    do_reset();
    chk("R11 cleared", 32'({hdr_done, cold_en, warm_en, in_ready}), 32'b0001);
    set_vecs(24'h111111, 24'h222222, 24'h333333, 24'h444444);
    build(8'h20, -1, 8'h00);
    stream(160, 0);
    chk("R11 fresh parse", 32'({hdr_done, hdr_err, cold_en, warm_en}), 32'b1010);
    lookup("R11 new vector", 1'b0, 2'd1, 1'b1);
  endtask

  initial begin
    t_reset();
    t_both_dup();
    t_cold_only();
    t_warm_only();
    t_bad_mode();
    t_bad_sync();
    t_early_and_restart();
    summary();
  end
endmodule